// File: doc/BRIEF.md
# Fuse Byte Program-and-Verify Sequencer

This block programs one byte of a one-time-programmable fuse array. It takes a byte address and a requested value, and it drives a single-outstanding command port on a fuse controller. That port carries three operations: read a byte, fire one program pulse at one bit, and write a cleaning value into the controller's data register. The fuse cells themselves and the register bus that reaches the controller are outside this block.

A request starts with a range check and a read of the whole byte. If every requested 1 is already present, the block finishes with success and sends nothing more. If not, it walks through the requested bits from the lowest to the highest. For each bit it re-reads the byte to see whether that bit is still clear. A clear bit gets a train of program pulses. Read-back verification starts only after a minimum number of pulses. The train ends when the bit reads as set or when the pulse budget runs out. A scrub write always follows the train. A failing bit raises a sticky error but does not stop the bits after it.

Top module: `fuse_prog_seq`

## Requirements
- R1: A request whose address is ARRAY_BYTES (1024) or more finishes with `done` and `error` high, and no command is issued.
- R2: Every accepted in-range request first issues one read (op 0) of the addressed byte. If `req_value & ~byte` is zero, the request finishes with success and no program or scrub command is issued.
- R3: Otherwise every bit set in `req_value` is visited in ascending order, from bit 0 to bit 7. Each visit starts with a read. A bit that reads as 1 is skipped with no pulse, and bits not set in `req_value` are never pulsed.
- R4: Program pulses (op 1) carry the bit index on `cmd_bit`. No read is issued for a bit until MIN_PULSES (4) pulses have been given to it. From then on one verify read follows every pulse.
- R5: Pulsing of a bit stops at the first verify read that shows it set. A bit that needs k pulses therefore receives max(k, MIN_PULSES) pulses.
- R6: A bit receives at most MAX_PULSES (20) pulses. If it still reads clear after the last one, the request reports `error`.
- R7: After a failing bit, the remaining requested bits are still processed. `error` stays set until the request completes.
- R8: Every bit that received pulses is followed by exactly one scrub command (op 2) with `cmd_wdata` equal to 8'h01.
- R9: A new command is issued only after `cmd_done` has answered the previous one. `cmd_addr` always equals the address of the request being served.
- R10: `done` is a single-cycle pulse with `busy` low. While `busy` is high, new requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | REQ_AW (16) | Requested byte address |
| req_value | input | 8 | Bits to be set to 1 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with `done` |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 2 | 0 read, 1 program pulse, 2 scrub |
| cmd_addr | output | ARR_AW (10) | Byte address of the command |
| cmd_bit | output | 3 | Bit index for program pulses |
| cmd_wdata | output | 8 | Scrub value (8'h01) on scrub, else zero |
| cmd_done | input | 1 | Controller completion of the outstanding command |
| cmd_rdata | input | 8 | Read data, valid with `cmd_done` |

## Verification
The main function is exercised with fuse cells that flip after a chosen number of pulses, set separately for each bit. Cells flipping before the fourth pulse reveal any verify read issued too early, and cells flipping between 5 and 20 pulses expose off-by-one stopping. Cells that never flip separate a correct 20-pulse budget and sticky error from one that aborts early or stops short. Patterns whose requested bits are already partly or fully set show whether the early exit and the per-bit skip send pulses they should not. Out-of-range addresses and a second request arriving mid-operation check that nothing reaches the command port when it must not.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_SCRUB = 2'd2
  } fuse_op_e;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_PRE_WT = 4'd1,
    ST_PICK   = 4'd2,
    ST_CHK_WT = 4'd3,
    ST_PRG_WT = 4'd4,
    ST_VER_WT = 4'd5,
    ST_SCR_WT = 4'd6,
    ST_DONE   = 4'd7
  } seq_state_e;

  localparam logic [7:0] SCRUB_VALUE = 8'h01;

endpackage

// File: rtl/fuse_rst_sync.sv
module fuse_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/fuse_pulse_ctr.sv
module fuse_pulse_ctr #(
  parameter int MIN_PULSES = 4,
  parameter int MAX_PULSES = 20
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              inc,
  output logic [$clog2(MAX_PULSES+1)-1:0]   count,
  output logic                              reach_min,
  output logic                              at_max
);
  localparam int CW = $clog2(MAX_PULSES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count     = cnt_q;
  // The pulse now completing is at least the MIN_PULSES-th one.
  assign reach_min = (cnt_q >= CW'(MIN_PULSES - 1));
  assign at_max    = (cnt_q >= CW'(MAX_PULSES));
endmodule

// File: rtl/fuse_bit_pick.sv
module fuse_bit_pick #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]         mask,
  output logic                     found,
  output logic [$clog2(WIDTH)-1:0] index
);
  localparam int IW = $clog2(WIDTH);

  always_comb begin
    found = 1'b0;
    index = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        index = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fuse_seq_pkg::*;
#(
  parameter int ARRAY_BYTES = 1024,
  parameter int REQ_AW      = 16,
  parameter int MIN_PULSES  = 4,
  parameter int MAX_PULSES  = 20,
  parameter int ARR_AW      = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [REQ_AW-1:0] req_addr,
  input  logic [7:0]        req_value,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [ARR_AW-1:0] cmd_addr,
  output logic [2:0]        cmd_bit,
  output logic [7:0]        cmd_wdata,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_rdata
);
  localparam int CW = $clog2(MAX_PULSES + 1);

  logic rst_ns;

  seq_state_e        state_q, state_d;
  logic [ARR_AW-1:0] addr_q, addr_d;
  logic [7:0]        val_q, val_d;
  logic [7:0]        remain_q, remain_d;
  logic [2:0]        bit_q, bit_d;
  logic              err_q, err_d;
  logic              cvalid_q, cvalid_d;
  fuse_op_e          cop_q, cop_d;

  logic          ctr_clr, ctr_inc;
  logic [CW-1:0] ctr_count;
  logic          ctr_min, ctr_max;
  logic          pick_found;
  logic [2:0]    pick_idx;
  logic          addr_ok;

  fuse_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  fuse_pulse_ctr #(
    .MIN_PULSES (MIN_PULSES),
    .MAX_PULSES (MAX_PULSES)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_ns),
    .clr       (ctr_clr),
    .inc       (ctr_inc),
    .count     (ctr_count),
    .reach_min (ctr_min),
    .at_max    (ctr_max)
  );

  fuse_bit_pick #(.WIDTH(8)) u_pick (
    .mask  (remain_q),
    .found (pick_found),
    .index (pick_idx)
  );

  assign addr_ok = ({16'd0, req_addr} < (16 + REQ_AW)'(ARRAY_BYTES));

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    val_d    = val_q;
    remain_d = remain_q;
    bit_d    = bit_q;
    err_d    = err_q;
    cvalid_d = 1'b0;
    cop_d    = cop_q;
    ctr_clr  = 1'b0;
    ctr_inc  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!addr_ok) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            addr_d   = req_addr[ARR_AW-1:0];
            val_d    = req_value;
            err_d    = 1'b0;
            cvalid_d = 1'b1;
            cop_d    = OP_READ;
            state_d  = ST_PRE_WT;
          end
        end
      end

      ST_PRE_WT: begin
        if (cmd_done) begin
          if ((val_q & ~cmd_rdata) == 8'h00) begin
            state_d = ST_DONE;
          end else begin
            remain_d = val_q;
            state_d  = ST_PICK;
          end
        end
      end

      ST_PICK: begin
        if (pick_found) begin
          bit_d    = pick_idx;
          remain_d = remain_q & ~(8'h01 << pick_idx);
          cvalid_d = 1'b1;
          cop_d    = OP_READ;
          state_d  = ST_CHK_WT;
        end else begin
          state_d = ST_DONE;
        end
      end

      ST_CHK_WT: begin
        if (cmd_done) begin
          if (cmd_rdata[bit_q]) begin
            state_d = ST_PICK;
          end else begin
            ctr_clr  = 1'b1;
            cvalid_d = 1'b1;
            cop_d    = OP_PROG;
            state_d  = ST_PRG_WT;
          end
        end
      end

      ST_PRG_WT: begin
        if (cmd_done) begin
          ctr_inc  = 1'b1;
          cvalid_d = 1'b1;
          if (ctr_min) begin
            cop_d   = OP_READ;
            state_d = ST_VER_WT;
          end else begin
            cop_d   = OP_PROG;
            state_d = ST_PRG_WT;
          end
        end
      end

      ST_VER_WT: begin
        if (cmd_done) begin
          cvalid_d = 1'b1;
          if (cmd_rdata[bit_q]) begin
            cop_d   = OP_SCRUB;
            state_d = ST_SCR_WT;
          end else if (ctr_max) begin
            err_d   = 1'b1;
            cop_d   = OP_SCRUB;
            state_d = ST_SCR_WT;
          end else begin
            cop_d   = OP_PROG;
            state_d = ST_PRG_WT;
          end
        end
      end

      ST_SCR_WT: begin
        if (cmd_done) state_d = ST_PICK;
      end

      ST_DONE: begin
        state_d = ST_IDLE;
      end

      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      val_q    <= '0;
      remain_q <= '0;
      bit_q    <= '0;
      err_q    <= 1'b0;
      cvalid_q <= 1'b0;
      cop_q    <= OP_READ;
    end else begin
      state_q  <= state_d;
      cvalid_q <= cvalid_d;
      err_q    <= err_d;
      if (state_q == ST_IDLE)  addr_q   <= addr_d;
      if (state_q == ST_IDLE)  val_q    <= val_d;
      if (state_q == ST_PICK || state_q == ST_PRE_WT) remain_q <= remain_d;
      if (state_q == ST_PICK)  bit_q    <= bit_d;
      if (cvalid_d)            cop_q    <= cop_d;
    end
  end

  assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done      = (state_q == ST_DONE);
  assign error     = err_q;
  assign cmd_valid = cvalid_q;
  assign cmd_op    = cop_q;
  assign cmd_addr  = addr_q;
  assign cmd_bit   = bit_q;
  assign cmd_wdata = (cop_q == OP_SCRUB) ? SCRUB_VALUE : 8'h00;

endmodule

// File: rtl/fuse_prog_seq_chk.sv
module fuse_prog_seq_chk #(
  parameter int MIN_PULSES = 4,
  parameter int MAX_PULSES = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_wdata,
  input logic       cmd_done
);
  logic       outst_q;
  logic [7:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      pcnt_q  <= 8'd0;
    end else begin
      if (cmd_valid)     outst_q <= 1'b1;
      else if (cmd_done) outst_q <= 1'b0;
      if (cmd_valid && cmd_op == 2'd2)                         pcnt_q <= 8'd0;
      else if (cmd_valid && cmd_op == 2'd1 && pcnt_q != 8'hFF) pcnt_q <= pcnt_q + 8'd1;
    end
  end

  assert_no_early_verify_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |-> (pcnt_q == 8'd0 || pcnt_q >= 8'(MIN_PULSES)));

  assert_pulse_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1) |-> (pcnt_q < 8'(MAX_PULSES)));

  assert_scrub_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |-> (cmd_wdata == 8'h01));

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !outst_q);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(
  .MIN_PULSES (MIN_PULSES),
  .MAX_PULSES (MAX_PULSES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_wdata (cmd_wdata),
  .cmd_done  (cmd_done)
);

// File: tb/sim_fuse_prog_seq.sv
`timescale 1ns/1ps
module sim_fuse_prog_seq;
  localparam int MINP = 4;
  localparam int MAXP = 20;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_addr;
  logic [7:0]  req_value;
  logic        busy, done, error;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [9:0]  cmd_addr;
  logic [2:0]  cmd_bit;
  logic [7:0]  cmd_wdata;
  logic        cmd_done;
  logic [7:0]  cmd_rdata;

  fuse_prog_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_value(req_value), .busy(busy), .done(done), .error(error),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_bit(cmd_bit), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
    .cmd_rdata(cmd_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Fuse controller model state
  logic [7:0] fuse;
  int pc[8];
  int need_a[8];
  int n_rd, n_pg, n_sc, bad_wd, bad_proto, bad_addr;
  logic [9:0] exp_addr;
  logic [7:0] resp;
  int lat;
  bit outst;

  // Expected values
  bit e_err;
  logic [7:0] e_fuse;
  int e_pg, e_sc, e_rd;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Controller responder
  initial begin
    cmd_done = 1'b0; cmd_rdata = 8'h00; outst = 0; lat = 0; resp = 8'h00;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      if (cmd_valid) begin
        if (outst) bad_proto++;
        else begin
          if (cmd_addr != exp_addr) bad_addr++;
          case (cmd_op)
            2'd0: begin n_rd++; resp = fuse; end
            2'd1: begin
              n_pg++;
              pc[cmd_bit]++;
              if (pc[cmd_bit] >= need_a[cmd_bit]) fuse[cmd_bit] = 1'b1;
              resp = fuse;
            end
            default: begin
              n_sc++;
              if (cmd_wdata != 8'h01) bad_wd++;
              resp = 8'h00;
            end
          endcase
          outst = 1;
          lat = 1 + int'($urandom_range(2));
        end
      end else if (outst) begin
        lat--;
        if (lat == 0) begin
          cmd_done = 1'b1;
          cmd_rdata = resp;
          outst = 0;
        end
      end
    end
  end

  function automatic void expect_of(input logic [15:0] a, input logic [7:0] init,
                                    input logic [7:0] val, input logic [39:0] nd);
    e_err = 0; e_fuse = init; e_pg = 0; e_sc = 0; e_rd = 0;
    if (a >= 16'd1024) begin
      e_err = 1;
      return;
    end
    e_rd = 1;
    if ((val & ~init) == 8'h00) return;
    for (int i = 0; i < 8; i++) begin
      if (val[i]) begin
        e_rd++;
        if (!init[i]) begin
          int n, p;
          n = int'(nd[i*5 +: 5]);
          e_sc++;
          if (n <= MAXP) begin
            p = (n > MINP) ? n : MINP;
            e_fuse[i] = 1'b1;
          end else begin
            p = MAXP;
            e_err = 1;
          end
          e_pg += p;
          e_rd += p - MINP + 1;
        end
      end
    end
  endfunction

  task automatic run_case(input string tag, input logic [15:0] a,
                          input logic [7:0] init, input logic [7:0] val,
                          input logic [39:0] nd, input bit poke);
    int t;
    fuse = init;
    for (int i = 0; i < 8; i++) begin pc[i] = 0; need_a[i] = int'(nd[i*5 +: 5]); end
    n_rd = 0; n_pg = 0; n_sc = 0; bad_wd = 0; bad_proto = 0; bad_addr = 0;
    exp_addr = a[9:0];
    expect_of(a, init, val, nd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_value = val;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy, "R10", "busy during request", int'(busy), 1);
      req_valid = 1'b1; req_addr = a ^ 16'h0001; req_value = 8'hFF;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, tag, "done reached", int'(done), 1);
    chk(error == e_err, tag, "error", int'(error), int'(e_err));
    chk(fuse == e_fuse, tag, "final byte", int'(fuse), int'(e_fuse));
    chk(n_pg == e_pg, tag, "pulse count", n_pg, e_pg);
    chk(n_rd == e_rd, tag, "read count", n_rd, e_rd);
    chk(n_sc == e_sc, "R8", "scrub count", n_sc, e_sc);
    chk(bad_wd == 0, "R8", "scrub value errors", bad_wd, 0);
    chk(bad_proto == 0, "R9", "overlapping commands", bad_proto, 0);
    chk(bad_addr == 0, "R9", "wrong command address", bad_addr, 0);
    @(negedge clk);
    chk(!done, "R10", "done single cycle", int'(done), 0);
  endtask

  function automatic logic [39:0] uni(input int n);
    return {8{5'(n)}};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_value = '0;
    fuse = 8'h00; exp_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !cmd_valid, "R10", "reset idle", int'({busy, done, cmd_valid}), 0);

    run_case("R1", 16'd1024, 8'h00, 8'hFF, uni(1), 0);
    run_case("R1", 16'hFFFF, 8'h00, 8'h01, uni(1), 0);
    run_case("R2", 16'd5, 8'hFF, 8'hA5, uni(1), 0);
    run_case("R2", 16'd6, 8'h3C, 8'h00, uni(1), 0);
    run_case("R4", 16'd1023, 8'h00, 8'h01, uni(1), 0);
    run_case("R4", 16'd1, 8'h00, 8'h02, uni(4), 0);
    run_case("R5", 16'd2, 8'h00, 8'h80, uni(7), 0);
    run_case("R6", 16'd3, 8'h00, 8'h10, uni(20), 0);
    run_case("R6", 16'd4, 8'h00, 8'h01, uni(31), 0);
    run_case("R7", 16'd9, 8'h00, 8'h81, {5'd6, 30'd0, 5'd31}, 0);
    run_case("R3", 16'd10, 8'h0F, 8'hFF, uni(5), 0);
    run_case("R3", 16'd11, 8'h40, 8'h5A, uni(9), 0);
    run_case("R10", 16'd12, 8'h00, 8'h22, uni(6), 1);

    for (int k = 0; k < 40; k++) begin
      logic [15:0] a;
      logic [7:0] init, val;
      logic [39:0] nd;
      a = (($urandom_range(9) == 0) ? 16'd1024 + 16'($urandom_range(2000)) : 16'($urandom_range(1023)));
      init = 8'($urandom) & 8'($urandom);
      val = 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        int n;
        n = int'($urandom_range(1, 23));
        if (n > MAXP) n = 31;
        nd[i*5 +: 5] = 5'(n);
      end
      run_case("R5", a, init, val, nd, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule